// File: doc/BRIEF.md
# Two-Bank Fetch Window Aligner

This block builds one fixed-width window of instruction bytes per cycle from an instruction cache whose blocks alternate between two banks. Bit 5 of the fetch address chooses the bank that holds the current block, so the block that follows it in sequence always sits in the other bank. When the fetch address lies so far into its block that the window would run past the block's end, the aligner takes the following block from the other bank in the same cycle. It also uses that bank's own tag-hit flag as a second tag check.

Both bank lines are rotated so that lane 0 of the window holds the byte at the fetch address, with the rest following in program order. A predicted-taken branch inside the window cuts the window off after the branch's last byte. If the first block misses, nothing is delivered. If only the following block misses, the window stops at the block boundary. The aligner also computes the next fetch address: the branch target when a taken branch was delivered, and otherwise the fetch address plus the number of bytes delivered. All outputs are registered one cycle after the request.

Top module: `fa_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_vld`, `out_mask`, `out_miss`, `out_split_miss`, `out_bytes` and `out_next_pc` are all zero.
- R2: The block that holds `fetch_pc` is read from bank `fetch_pc[5]` (0 selects `line0`/`hit0`, 1 selects `line1`/`hit1`). The block that follows it is read from the other bank.
- R3: With o = `fetch_pc[4:0]` and o ≤ 16, lane i (bits 8i+7:8i) of `out_bytes` holds byte o+i of the first block, for all 16 lanes. The other bank's hit flag has no effect.
- R4: With o > 16, lanes i with o+i ≥ 32 hold byte o+i−32 of the other bank's line. Lanes below that index hold bytes of the first block.
- R5: If the first block's hit flag is 0, then one cycle later `out_mask` = 0, `out_miss` = 1 and `out_next_pc` = `fetch_pc`. A branch input does not change this.
- R6: If the window crosses the block end and the other bank misses, lanes with o+i ≥ 32 are invalid. `out_split_miss` is 1 only if at least one such lane would otherwise have been valid.
- R7: With `br_vld` = 1, lanes above `br_lane` are invalid and lane `br_lane` is kept. Every invalid lane of `out_bytes` reads 0x00, and `out_mask` is always a contiguous run starting at lane 0.
- R8: When the first block hits and no taken branch is delivered, `out_next_pc` = `fetch_pc` + popcount(`out_mask`).
- R9: When `br_vld` = 1 and lane `br_lane` is valid, `out_next_pc` = `br_tgt`. If the branch lane was cut off by a miss, R8 applies instead.
- R10: With `fetch_vld` = 0, the next cycle has `out_vld` = 0, `out_mask` = 0, `out_miss` = 0 and `out_split_miss` = 0, and `out_next_pc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Fetch request this cycle |
| fetch_pc | input | 32 | Fetch byte address |
| line0 | input | 256 | Block read from bank 0, byte k at bits 8k+7:8k |
| line1 | input | 256 | Block read from bank 1 |
| hit0 | input | 1 | Tag hit for the bank 0 block |
| hit1 | input | 1 | Tag hit for the bank 1 block |
| br_vld | input | 1 | A predicted-taken branch ends inside the window |
| br_lane | input | 4 | Window lane of the branch's last byte |
| br_tgt | input | 32 | Predicted branch target |
| out_vld | output | 1 | Registered result is for a request |
| out_bytes | output | 128 | Aligned window, lane 0 at the fetch address |
| out_mask | output | 16 | Per-lane valid bits |
| out_miss | output | 1 | First block missed |
| out_split_miss | output | 1 | Window shortened by a miss of the following block |
| out_next_pc | output | 32 | Next fetch address |

## Verification
The branch cut and the second-block miss cut can both hit the same window when the fetch crosses a block end. Directed cases set up a crossing fetch with the other bank missing. In one case the branch lane lies before the boundary: the branch alone must decide the mask, no split miss may be reported, and the target must be taken. In the other case the branch lane lies past the boundary: the miss must decide the mask, the split miss must be reported, and the redirect must be dropped in favour of the sequential address. The first-block miss combined with a branch is checked the same way.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int FA_FETCH_BYTES = 16;
    localparam int FA_BLOCK_BYTES = 32;
    localparam int FA_PC_W        = 32;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_OK    = 2'd1,
        FS_MISS  = 2'd2,
        FS_SPLIT = 2'd3
    } fa_status_e;

    function automatic fa_status_e fa_classify(input logic req, input logic first_hit,
                                               input logic split);
        if (!req)            return FS_IDLE;
        else if (!first_hit) return FS_MISS;
        else if (split)      return FS_SPLIT;
        else                 return FS_OK;
    endfunction
endpackage

// File: rtl/fa_bank_pick.sv
module fa_bank_pick #(
    parameter int BLOCK_BYTES = fa_pkg::FA_BLOCK_BYTES,
    parameter int PC_W        = fa_pkg::FA_PC_W,
    localparam int OFF_W      = $clog2(BLOCK_BYTES),
    localparam int LINE_W     = BLOCK_BYTES * 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [LINE_W-1:0] line0,
    input  logic [LINE_W-1:0] line1,
    input  logic              hit0,
    input  logic              hit1,
    output logic [LINE_W-1:0] first_line,
    output logic [LINE_W-1:0] second_line,
    output logic              first_hit,
    output logic              second_hit,
    output logic [OFF_W-1:0]  off
);
    logic bank_sel;

    always_comb begin
        bank_sel    = pc[OFF_W];
        off         = pc[OFF_W-1:0];
        first_line  = bank_sel ? line1 : line0;
        second_line = bank_sel ? line0 : line1;
        first_hit   = bank_sel ? hit1  : hit0;
        second_hit  = bank_sel ? hit0  : hit1;
    end
endmodule

// File: rtl/fa_lane_route.sv
module fa_lane_route #(
    parameter int FETCH_BYTES = fa_pkg::FA_FETCH_BYTES,
    parameter int BLOCK_BYTES = fa_pkg::FA_BLOCK_BYTES,
    localparam int OFF_W      = $clog2(BLOCK_BYTES),
    localparam int LINE_W     = BLOCK_BYTES * 8,
    localparam int WIN_W      = FETCH_BYTES * 8
) (
    input  logic [OFF_W-1:0]       off,
    input  logic [LINE_W-1:0]      first_line,
    input  logic [LINE_W-1:0]      second_line,
    output logic [WIN_W-1:0]       lane_bytes,
    output logic [FETCH_BYTES-1:0] from_second
);
    for (genvar i = 0; i < FETCH_BYTES; i++) begin : g_lane
        logic [OFF_W:0]   pos;
        logic [OFF_W-1:0] idx;
        fa_pkg::byte_t    b_first;
        fa_pkg::byte_t    b_second;

        assign pos      = {1'b0, off} + (OFF_W+1)'(i);
        assign idx      = pos[OFF_W-1:0];
        assign b_first  = first_line[8*idx +: 8];
        assign b_second = second_line[8*idx +: 8];
        assign from_second[i]    = pos[OFF_W];
        assign lane_bytes[8*i +: 8] = pos[OFF_W] ? b_second : b_first;
    end
endmodule

// File: rtl/fa_lane_mask.sv
module fa_lane_mask #(
    parameter int FETCH_BYTES = fa_pkg::FA_FETCH_BYTES,
    localparam int LANE_W     = $clog2(FETCH_BYTES),
    localparam int CNT_W      = LANE_W + 1
) (
    input  logic                   req,
    input  logic                   first_hit,
    input  logic                   second_hit,
    input  logic [FETCH_BYTES-1:0] from_second,
    input  logic                   br_vld,
    input  logic [LANE_W-1:0]      br_lane,
    output logic [FETCH_BYTES-1:0] valid,
    output logic [CNT_W-1:0]       count,
    output logic                   split,
    output logic                   br_taken
);
    logic [FETCH_BYTES-1:0] keep_br;
    logic [FETCH_BYTES-1:0] lost_to_miss;

    always_comb begin
        count = '0;
        for (int i = 0; i < FETCH_BYTES; i++) begin
            keep_br[i]      = !br_vld || (LANE_W'(i) <= br_lane);
            valid[i]        = req && first_hit && keep_br[i] && (!from_second[i] || second_hit);
            lost_to_miss[i] = req && first_hit && keep_br[i] && from_second[i] && !second_hit;
            count           = count + CNT_W'(valid[i]);
        end
        split    = |lost_to_miss;
        br_taken = req && br_vld && valid[br_lane];
    end
endmodule

// File: rtl/fa_aligner.sv
module fa_aligner #(
    parameter int FETCH_BYTES = fa_pkg::FA_FETCH_BYTES,
    parameter int BLOCK_BYTES = fa_pkg::FA_BLOCK_BYTES,
    parameter int PC_W        = fa_pkg::FA_PC_W,
    localparam int OFF_W      = $clog2(BLOCK_BYTES),
    localparam int LANE_W     = $clog2(FETCH_BYTES),
    localparam int CNT_W      = LANE_W + 1,
    localparam int LINE_W     = BLOCK_BYTES * 8,
    localparam int WIN_W      = FETCH_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fetch_vld,
    input  logic [PC_W-1:0]        fetch_pc,
    input  logic [LINE_W-1:0]      line0,
    input  logic [LINE_W-1:0]      line1,
    input  logic                   hit0,
    input  logic                   hit1,
    input  logic                   br_vld,
    input  logic [LANE_W-1:0]      br_lane,
    input  logic [PC_W-1:0]        br_tgt,
    output logic                   out_vld,
    output logic [WIN_W-1:0]       out_bytes,
    output logic [FETCH_BYTES-1:0] out_mask,
    output logic                   out_miss,
    output logic                   out_split_miss,
    output logic [PC_W-1:0]        out_next_pc
);
    import fa_pkg::*;

    logic [LINE_W-1:0]      first_line, second_line;
    logic                   first_hit, second_hit;
    logic [OFF_W-1:0]       off;
    logic [WIN_W-1:0]       raw_bytes;
    logic [FETCH_BYTES-1:0] from_second;
    logic [FETCH_BYTES-1:0] valid;
    logic [CNT_W-1:0]       count;
    logic                   split, br_taken;
    logic [WIN_W-1:0]       clean_bytes;
    logic [PC_W-1:0]        next_pc_d;
    fa_status_e             status_d, status_q;

    fa_bank_pick #(.BLOCK_BYTES(BLOCK_BYTES), .PC_W(PC_W)) u_pick (
        .pc(fetch_pc), .line0(line0), .line1(line1), .hit0(hit0), .hit1(hit1),
        .first_line(first_line), .second_line(second_line),
        .first_hit(first_hit), .second_hit(second_hit), .off(off)
    );

    fa_lane_route #(.FETCH_BYTES(FETCH_BYTES), .BLOCK_BYTES(BLOCK_BYTES)) u_route (
        .off(off), .first_line(first_line), .second_line(second_line),
        .lane_bytes(raw_bytes), .from_second(from_second)
    );

    fa_lane_mask #(.FETCH_BYTES(FETCH_BYTES)) u_mask (
        .req(fetch_vld), .first_hit(first_hit), .second_hit(second_hit),
        .from_second(from_second), .br_vld(br_vld), .br_lane(br_lane),
        .valid(valid), .count(count), .split(split), .br_taken(br_taken)
    );

    // Zero every lane that is not delivered.
    always_comb begin
        for (int i = 0; i < FETCH_BYTES; i++)
            clean_bytes[8*i +: 8] = valid[i] ? raw_bytes[8*i +: 8] : 8'h00;
    end

    always_comb begin
        status_d = fa_classify(fetch_vld, first_hit, split);
        unique case (status_d)
            FS_IDLE: next_pc_d = out_next_pc;
            FS_MISS: next_pc_d = fetch_pc;
            default: next_pc_d = br_taken ? br_tgt : fetch_pc + PC_W'(count);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q    <= FS_IDLE;
            out_bytes   <= '0;
            out_mask    <= '0;
            out_next_pc <= '0;
        end else begin
            status_q    <= status_d;
            out_bytes   <= clean_bytes;
            out_mask    <= valid;
            out_next_pc <= next_pc_d;
        end
    end

    assign out_vld        = (status_q != FS_IDLE);
    assign out_miss       = (status_q == FS_MISS);
    assign out_split_miss = (status_q == FS_SPLIT);

    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        out_miss |-> (out_mask == '0));                                          // R5
    AST_MISS_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !first_hit) |=> (out_next_pc == $past(fetch_pc)));        // R5
    AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (rst)
        ((out_mask + FETCH_BYTES'(1)) & out_mask) == '0);                       // R7
    AST_SPLIT_DROPS_TAIL: assert property (@(posedge clk) disable iff (rst)
        out_split_miss |-> !out_mask[FETCH_BYTES-1]);                            // R6
    AST_SPLIT_NOT_MISS: assert property (@(posedge clk) disable iff (rst)
        !(out_miss && out_split_miss));                                          // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |=> (!out_vld && out_mask == '0 && $stable(out_next_pc)));   // R10
endmodule

// File: tb/tb_fa_aligner.sv
`timescale 1ns/1ps
module tb_fa_aligner;
    logic         clk = 1'b0;
    logic         rst;
    logic         fetch_vld;
    logic [31:0]  fetch_pc;
    logic [255:0] line0, line1;
    logic         hit0, hit1;
    logic         br_vld;
    logic [3:0]   br_lane;
    logic [31:0]  br_tgt;
    logic         out_vld;
    logic [127:0] out_bytes;
    logic [15:0]  out_mask;
    logic         out_miss, out_split_miss;
    logic [31:0]  out_next_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fa_aligner dut (
        .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .line0(line0), .line1(line1), .hit0(hit0), .hit1(hit1),
        .br_vld(br_vld), .br_lane(br_lane), .br_tgt(br_tgt),
        .out_vld(out_vld), .out_bytes(out_bytes), .out_mask(out_mask),
        .out_miss(out_miss), .out_split_miss(out_split_miss), .out_next_pc(out_next_pc)
    );

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill(byte unsigned seed);
        for (int k = 0; k < 32; k++) begin
            line0[8*k +: 8] = seed ^ 8'(k);
            line1[8*k +: 8] = seed ^ 8'h80 ^ 8'(k);
        end
    endtask

    // Drive one request, compute the expected window from the requirements, compare.
    task automatic run(string req, logic fv, logic [31:0] pc, logic h0, logic h1,
                       logic bv, logic [3:0] bl, logic [31:0] tgt, byte unsigned seed);
        logic [127:0] e_bytes;
        logic [15:0]  e_mask;
        logic         e_split, fhit, shit, bank, br_ok;
        logic [31:0]  e_pc, prev_pc;
        int           o, cnt;
        @(negedge clk);
        prev_pc = out_next_pc;
        fill(seed);
        fetch_vld = fv; fetch_pc = pc; hit0 = h0; hit1 = h1;
        br_vld = bv; br_lane = bl; br_tgt = tgt;
        bank = pc[5]; o = int'(pc[4:0]);
        fhit = bank ? h1 : h0;
        shit = bank ? h0 : h1;
        e_bytes = '0; e_mask = '0; e_split = 1'b0; cnt = 0;
        for (int i = 0; i < 16; i++) begin
            int  p;
            bit  keep, sec;
            byte unsigned b;
            p    = o + i;
            sec  = (p >= 32);
            keep = !bv || (i <= int'(bl));
            b    = (sec ? 8'(p - 32) : 8'(p)) ^ seed ^ (((sec ? !bank : bank)) ? 8'h80 : 8'h00);
            if (fv && fhit && keep && (!sec || shit)) begin
                e_mask[i] = 1'b1;
                e_bytes[8*i +: 8] = b;
                cnt++;
            end
            if (fv && fhit && keep && sec && !shit) e_split = 1'b1;
        end
        br_ok = bv && e_mask[bl];
        if (!fv)        e_pc = prev_pc;
        else if (!fhit) e_pc = pc;
        else if (br_ok) e_pc = tgt;
        else            e_pc = pc + 32'(cnt);
        @(negedge clk);
        chk(req, "out_vld", 128'(out_vld), 128'(fv));
        chk(req, "out_mask", 128'(out_mask), 128'(e_mask));
        chk(req, "out_bytes", out_bytes, e_bytes);
        chk(req, "out_miss", 128'(out_miss), 128'(fv && !fhit));
        chk(req, "out_split_miss", 128'(out_split_miss), 128'(e_split));
        chk(req, "out_next_pc", 128'(out_next_pc), 128'(e_pc));
    endtask

    task automatic t_reset();
        rst = 1'b1; fetch_vld = 1'b1; fetch_pc = 32'h1000; fill(8'h11);
        hit0 = 1'b1; hit1 = 1'b1; br_vld = 1'b0; br_lane = '0; br_tgt = '0;
        repeat (3) @(negedge clk);
        chk("R1", "out_vld", 128'(out_vld), 128'(0));
        chk("R1", "out_mask", 128'(out_mask), 128'(0));
        chk("R1", "out_bytes", out_bytes, 128'(0));
        chk("R1", "out_next_pc", 128'(out_next_pc), 128'(0));
        rst = 1'b0;
        chk("R1", "out_miss", 128'(out_miss), 128'(0));
        chk("R1", "out_split_miss", 128'(out_split_miss), 128'(0));
    endtask

    task automatic t_in_block();
        run("R2 R3 R8", 1, 32'h0000_1000, 1, 1, 0, 4'd0, 32'h0, 8'h21);
        run("R2 R3 R8", 1, 32'h0000_1030, 0, 1, 0, 4'd0, 32'h0, 8'h32); // bank1, other bank misses, unused
        run("R3 R8",    1, 32'h0000_1047, 1, 0, 0, 4'd0, 32'h0, 8'h05);
    endtask

    task automatic t_cross();
        run("R2 R4 R8", 1, 32'h0000_1014, 1, 1, 0, 4'd0, 32'h0, 8'h43);
        run("R2 R4 R8", 1, 32'h0000_103C, 1, 1, 0, 4'd0, 32'h0, 8'h54);
        run("R4 R8",    1, 32'h0000_1011, 1, 1, 0, 4'd0, 32'h0, 8'h65);
    endtask

    task automatic t_first_miss();
        run("R5", 1, 32'h0000_1014, 0, 1, 0, 4'd0, 32'h0,       8'h76);
        run("R5", 1, 32'h0000_1020, 1, 0, 1, 4'd2, 32'h0000_9000, 8'h87);
    endtask

    task automatic t_second_miss();
        run("R6 R8", 1, 32'h0000_1014, 1, 0, 0, 4'd0, 32'h0, 8'h98);
        run("R6 R8", 1, 32'h0000_103F, 0, 1, 0, 4'd0, 32'h0, 8'hA9);
    endtask

    task automatic t_branch();
        run("R7 R9", 1, 32'h0000_1000, 1, 1, 1, 4'd5,  32'h0000_2000, 8'hBA);
        run("R7 R9", 1, 32'h0000_1018, 1, 1, 1, 4'd15, 32'h0000_3000, 8'hCB);
        run("R7 R9", 1, 32'h0000_1014, 1, 1, 1, 4'd0,  32'h0000_4000, 8'hDC);
    endtask

    task automatic t_branch_and_split();
        run("R6 R7 R9", 1, 32'h0000_1014, 1, 0, 1, 4'd3,  32'h0000_5000, 8'hED); // branch before boundary
        run("R6 R9 R8", 1, 32'h0000_1014, 1, 0, 1, 4'd14, 32'h0000_6000, 8'hFE); // branch beyond boundary
    endtask

    task automatic t_idle();
        run("R10", 0, 32'h0000_1014, 0, 0, 1, 4'd3, 32'h0000_7000, 8'h0F);
        run("R10", 0, 32'h0000_1000, 1, 1, 0, 4'd0, 32'h0,        8'h1E);
    endtask

    initial begin
        t_reset();
        t_in_block();
        t_cross();
        t_first_miss();
        t_second_miss();
        t_branch();
        t_branch_and_split();
        t_idle();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule